// File: doc/BRIEF.md
# Automatic Power-Down Controller

This block manages power for a programmable memory-and-logic peripheral that sits on a microcontroller bus. Two small control registers, reached through a plain address/data/write-strobe port, hold the power options. The first register holds the automatic power-down enable, a turbo-off control, and two separate clock-disconnect controls: one for the logic AND array and one for the output macrocells. The second register holds seven per-signal masks. Each mask keeps one bus control signal out of the logic array.

The controller samples the address-latch strobe on every input-clock edge and counts consecutive cycles with no strobe transition. When automatic power-down is enabled, the block enters power-down after 15 such cycles. A new strobe transition wakes it, and so does reset. An active-low chip-select input drives the three memory enables and the I/O access enable. While the block is powered down, the memory enables are held off. The I/O access enable always follows chip select.

Top module: `apd_ctrl`

## Requirements
- R1: After reset, both registers read 0, pd_o is 0, turbo_off_o is 0, both clock enables are 1 and in_block_o is 0.
- R2: A write is taken on a rising clock edge while cfg_we_i is 1. At address 0, bits 1, 3, 4 and 5 are stored and the other bits read 0. At address 2, bits 6:0 are stored and bit 7 reads 0. Addresses 1 and 3 read 0 and ignore writes. cfg_rdata_o shows the register at cfg_addr_i.
- R3: While bit 1 of register 0 (automatic power-down enable) is 0, pd_o never rises.
- R4: A strobe edge is sampled at a rising clock edge when strobe_i differs from its value at the previous rising edge. With the enable set, pd_o rises at the 15th rising edge after the last edge where a strobe edge was sampled. It stays 0 at the 14th.
- R5: A strobe edge sampled at a rising clock edge clears pd_o at that edge and restarts the idle count.
- R6: Clearing the enable bit clears pd_o at the next rising edge.
- R7: Asserting rst_ni low clears pd_o and both registers at once, without waiting for a clock.
- R8: turbo_off_o equals bit 3 of register 0. and_clk_en_o is the inverse of bit 4. mc_clk_en_o is the inverse of bit 5. Each bit acts alone.
- R9: in_block_o[i] equals bit i of register 2, for i from 0 to 6.
- R10: mem_en_o[0] (primary flash), mem_en_o[1] (secondary flash) and mem_en_o[2] (SRAM) are 1 only when sel_ni is 0 and pd_o is 0. io_en_o is the inverse of sel_ni, whatever the value of pd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data |
| strobe_i | input | 1 | Address-latch strobe |
| sel_ni | input | 1 | Active-low chip select |
| pd_o | output | 1 | Power-down active |
| mem_en_o | output | 3 | Primary flash, secondary flash and SRAM enables |
| io_en_o | output | 1 | I/O block access enable |
| turbo_off_o | output | 1 | Turbo off, so the logic may idle to standby |
| and_clk_en_o | output | 1 | Clock enable for the logic AND array |
| mc_clk_en_o | output | 1 | Clock enable for the output macrocells |
| in_block_o | output | 7 | Per-signal input blocking masks |

## Verification
A wrong idle count moves the rising edge of pd_o earlier or later than the 15th idle edge. The bench sees this on the exact cycle, and it shows a second time through mem_en_o, which switches off with pd_o. A stale strobe sample either misses a wake-up or raises a false one on the next clock. A corrupted register bit shows at once on the matching clock-enable, turbo or mask output, and on the read-back port in the same cycle.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MSK = 2'd2;
  localparam int unsigned BIT_APD   = 1;
  localparam int unsigned BIT_TURBO = 3;
  localparam int unsigned BIT_ANDCK = 4;
  localparam int unsigned BIT_MCCK  = 5;
  localparam logic [DATA_W-1:0] MASK_CTL =
    DATA_W'((1 << BIT_APD) | (1 << BIT_TURBO) | (1 << BIT_ANDCK) | (1 << BIT_MCCK));
endpackage

// File: rtl/apd_regs.sv
module apd_regs
  import apd_pkg::*;
#(
  parameter int unsigned NUM_BLOCK = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 apd_en_o,
  output logic                 turbo_off_o,
  output logic                 and_ck_off_o,
  output logic                 mc_ck_off_o,
  output logic [NUM_BLOCK-1:0] blk_o
);
  localparam logic [DATA_W-1:0] MASK_MSK = DATA_W'((1 << NUM_BLOCK) - 1);

  logic [DATA_W-1:0] ctl_q, ctl_d, msk_q, msk_d;
  logic              ctl_en, msk_en;

  always_comb begin
    ctl_en = we_i && (addr_i == ADDR_CTL);
    msk_en = we_i && (addr_i == ADDR_MSK);
    ctl_d  = wdata_i & MASK_CTL;
    msk_d  = wdata_i & MASK_MSK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      msk_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (msk_en) msk_q <= msk_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTL: rdata_o = ctl_q;
      ADDR_MSK: rdata_o = msk_q;
      default:  rdata_o = '0;
    endcase
  end

  assign apd_en_o     = ctl_q[BIT_APD];
  assign turbo_off_o  = ctl_q[BIT_TURBO];
  assign and_ck_off_o = ctl_q[BIT_ANDCK];
  assign mc_ck_off_o  = ctl_q[BIT_MCCK];
  assign blk_o        = msk_q[NUM_BLOCK-1:0];

  // R2: a control write lands masked on the next edge
  p_wr_ctl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTL) |=> (ctl_q == ($past(wdata_i) & MASK_CTL)));

  // R2: writes to unused addresses change nothing
  p_wr_hole_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_CTL && addr_i != ADDR_MSK) |=> ($stable(ctl_q) && $stable(msk_q)));
endmodule

// File: rtl/apd_idle.sv
module apd_idle #(
  parameter int unsigned IDLE_CYCLES = 15,
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic apd_en_i,
  output logic pd_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic             strobe_q;
  logic             edge_w;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pd_q, pd_d;

  always_comb begin
    edge_w = strobe_i ^ strobe_q;
    if (edge_w)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_W'(1);
    pd_d = !edge_w && apd_en_i && (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
      pd_q     <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      cnt_q    <= cnt_d;
      pd_q     <= pd_d;
    end
  end

  assign pd_o = pd_q;

  // R3, R6: no power-down while disabled
  p_off_when_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apd_en_i |=> !pd_q);

  // R5: a strobe transition always wakes
  p_wake_on_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i != strobe_q) |=> !pd_q);

  // R4: power-down only with a full idle window behind it
  p_pd_full_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/apd_sel.sv
module apd_sel #(
  parameter int unsigned NUM_MEM = 3
) (
  input  logic               sel_ni,
  input  logic               pd_i,
  output logic [NUM_MEM-1:0] mem_en_o,
  output logic               io_en_o
);
  for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
    assign mem_en_o[g] = !sel_ni && !pd_i;
  end
  assign io_en_o = !sel_ni;
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 15,
  parameter int unsigned NUM_BLOCK   = 7,
  parameter int unsigned NUM_MEM     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  output logic [DATA_W-1:0]    cfg_rdata_o,
  input  logic                 strobe_i,
  input  logic                 sel_ni,
  output logic                 pd_o,
  output logic [NUM_MEM-1:0]   mem_en_o,
  output logic                 io_en_o,
  output logic                 turbo_off_o,
  output logic                 and_clk_en_o,
  output logic                 mc_clk_en_o,
  output logic [NUM_BLOCK-1:0] in_block_o
);
  logic rst_s1_q, rst_n;
  logic apd_en, and_ck_off, mc_ck_off;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  apd_regs #(.NUM_BLOCK(NUM_BLOCK)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .apd_en_o    (apd_en),
    .turbo_off_o (turbo_off_o),
    .and_ck_off_o(and_ck_off),
    .mc_ck_off_o (mc_ck_off),
    .blk_o       (in_block_o)
  );

  apd_idle #(.IDLE_CYCLES(IDLE_CYCLES)) idle_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .strobe_i(strobe_i),
    .apd_en_i(apd_en),
    .pd_o    (pd_o)
  );

  apd_sel #(.NUM_MEM(NUM_MEM)) sel_i (
    .sel_ni  (sel_ni),
    .pd_i    (pd_o),
    .mem_en_o(mem_en_o),
    .io_en_o (io_en_o)
  );

  assign and_clk_en_o = !and_ck_off;
  assign mc_clk_en_o  = !mc_ck_off;

  // R10: memories stay off through power-down
  p_mem_off_in_pd_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    pd_o |-> (mem_en_o == '0));

  // R8: clock enables follow the written bits one edge later
  p_clk_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == ADDR_CTL) |=>
      (and_clk_en_o == !$past(cfg_wdata_i[BIT_ANDCK]) &&
       mc_clk_en_o  == !$past(cfg_wdata_i[BIT_MCCK])));
endmodule

// File: tb/apd_ctrl_tb_top.sv
module apd_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       strb, seln;
  logic       pd;
  logic [2:0] mem_en;
  logic       io_en, turbo_off, and_en, mc_en;
  logic [6:0] blk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic [7:0] m_ctl, m_msk;
  logic       m_prev, m_pd;
  int         m_cnt;

  always #2 clk = ~clk;

  apd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .strobe_i(strb), .sel_ni(seln),
    .pd_o(pd), .mem_en_o(mem_en), .io_en_o(io_en), .turbo_off_o(turbo_off),
    .and_clk_en_o(and_en), .mc_clk_en_o(mc_en), .in_block_o(blk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctl;
      2'd2:    return m_msk;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_mem();
    return (!seln && !m_pd) ? 3'b111 : 3'b000;
  endfunction

  task automatic model_reset();
    m_ctl = 8'h00; m_msk = 8'h00; m_prev = 1'b0; m_pd = 1'b0; m_cnt = 0;
  endtask

  task automatic check_all();
    check("R2 rdata",    {24'd0, rdata}, {24'd0, exp_rd(addr)});
    check("R4/R5 pd",    {31'd0, pd}, {31'd0, m_pd});
    check("R10 mem_en",  {29'd0, mem_en}, {29'd0, exp_mem()});
    check("R10 io_en",   {31'd0, io_en}, {31'd0, !seln});
    check("R8 turbo",    {31'd0, turbo_off}, {31'd0, m_ctl[3]});
    check("R8 and_clk",  {31'd0, and_en}, {31'd0, !m_ctl[4]});
    check("R8 mc_clk",   {31'd0, mc_en}, {31'd0, !m_ctl[5]});
    check("R9 in_block", {25'd0, blk}, {25'd0, m_msk[6:0]});
  endtask

  // called at a falling edge: drive, step model for the next rising edge, wait, check
  task automatic cycle(input logic s, input logic cs, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
    logic e;
    strb = s; seln = cs; we = w; addr = a; wdata = d;
    e = (s != m_prev);
    m_prev = s;
    if (e) m_cnt = 0; else if (m_cnt < 15) m_cnt++;
    m_pd = !e && m_ctl[1] && (m_cnt == 15);
    if (w && a == 2'd0) m_ctl = d & 8'b0011_1010;
    if (w && a == 2'd2) m_msk = d & 8'h7f;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; strb = 1'b0; seln = 1'b1; we = 1'b0; addr = 2'd0; wdata = 8'h00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cycle(1'b1, 1'b1, 1'b0, 2'd0, 8'h00); // sync strobe edge restarts idle count
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    rst_n = 1'b0; strb = 1'b0; seln = 1'b1; we = 1'b0; addr = 2'd0; wdata = 8'h00;
    model_reset();
    @(negedge clk);
    // R1: reset state
    check("R1 pd",       {31'd0, pd}, 32'd0);
    check("R1 ctl",      {24'd0, rdata}, 32'd0);
    check("R1 turbo",    {31'd0, turbo_off}, 32'd0);
    check("R1 clk_en",   {30'd0, and_en, mc_en}, 32'd3);
    check("R1 in_block", {25'd0, blk}, 32'd0);
    addr = 2'd2; #0;
    @(negedge clk);
    check("R1 msk",      {24'd0, rdata}, 32'd0);
    do_reset();

    // R3: long idle with enable clear never powers down
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R3 no pd when disabled", {31'd0, pd}, 32'd0);

    // R2: write map, unused addresses and bits
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'hff);
    check("R2 ctl masked", {24'd0, rdata}, 32'h3a);
    cycle(1'b1, 1'b0, 1'b1, 2'd2, 8'hff);
    check("R2 msk masked", {24'd0, rdata}, 32'h7f);
    cycle(1'b1, 1'b0, 1'b1, 2'd1, 8'h55);
    check("R2 hole reads 0", {24'd0, rdata}, 32'h0);
    cycle(1'b1, 1'b0, 1'b1, 2'd3, 8'h00);
    cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R2 hole write ignored", {24'd0, rdata}, 32'h3a);

    // R8: clock bits act alone
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'h10);
    check("R8 and only", {30'd0, and_en, mc_en}, 32'd1);
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'h20);
    check("R8 mc only", {30'd0, and_en, mc_en}, 32'd2);

    // R4: exact 15-cycle window
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'h02);
    cycle(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    for (int i = 0; i < 14; i++) cycle(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R4 no pd at 14", {31'd0, pd}, 32'd0);
    cycle(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R4 pd at 15", {31'd0, pd}, 32'd1);
    check("R10 mem off in pd", {29'd0, mem_en}, 32'd0);
    check("R10 io on in pd", {31'd0, io_en}, 32'd1);

    // R5: strobe edge wakes at once
    cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R5 wake", {31'd0, pd}, 32'd0);
    for (int i = 0; i < 15; i++) cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R5 re-enter", {31'd0, pd}, 32'd1);

    // R6: clearing the enable leaves power-down
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'h00);
    cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R6 exit on disable", {31'd0, pd}, 32'd0);

    // R7: async reset leaves power-down
    cycle(1'b1, 1'b0, 1'b1, 2'd0, 8'h02);
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R7 pd before reset", {31'd0, pd}, 32'd1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R7 pd async clear", {31'd0, pd}, 32'd0);
    check("R7 ctl async clear", {24'd0, rdata}, 32'd0);
    do_reset();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, cs, w;
      logic [1:0] a;
      logic [7:0] d;
      s  = (($urandom % 24) == 0) ? !m_prev : m_prev;
      cs = $urandom % 2;
      w  = (($urandom % 10) == 0);
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (w && a == 2'd0 && ($urandom % 4) != 0) d[1] = 1'b1;
      cycle(s, cs, w, a, d);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule